// File: doc/BRIEF.md
# I2C Slave Controller with Low-Clock Address Wake-Up

This block is a 7-bit-address I2C target that runs on a peripheral clock. It watches open-drain SCL and SDA, detects start and stop conditions, compares the address byte with its own address, and acknowledges it. On a write transfer it shifts bytes into a receive register. On a read transfer it shifts a transmit register onto SDA, most significant bit first. It can hold SCL low between bytes until the host side is ready, and it can pass both bus inputs through a glitch filter.

A low-speed wake-up mode exists for the case where the peripheral clock has been slowed down to save power. In this mode the address comparison uses the synchronised bus lines directly, without the filter. A matching address is answered with NAK and raises a one-cycle wake-up pulse. Firmware then raises the clock and clears the mode, and the master's retry is acknowledged normally. No data byte is ever moved while the mode is on.

The control bits, own address and byte registers appear as plain ports. The surrounding register file owns them.

Top module: `i2c_wake_slave`

## Requirements
- R1: After reset, `sda_oe`, `scl_oe`, `rx_ready`, `wake_irq` and `stop_seen` are all 0, so both bus lines are released.
- R2: A stop condition (SDA rising while SCL is high) returns the slave to idle, releases both lines and pulses `stop_seen` high for one clock. A start is SDA falling while SCL is high.
- R3: With `cfg_comm`=1 and `cfg_wake`=0, the slave pulls SDA low in the ninth clock only when the first seven bits after a start equal `own_addr` (sent MSB first). The eighth bit is R/W, 0 for a write and 1 for a read. Every other address is left unanswered.
- R4: With `cfg_comm`=0, the slave's own address is not acknowledged, so the master reads SDA high in the ninth clock.
- R5: In a write transfer, each data byte is assembled MSB first into `rx_data`, `rx_ready` is set, and the byte is ACKed. A one-cycle `rx_take` clears `rx_ready`.
- R6: In a read transfer, the slave drives the byte captured by `tx_load`, MSB first. After the master answers a byte with NAK (SDA high in the ninth clock), the slave releases SDA and sends nothing more until the next start.
- R7: With `cfg_stretch`=1, SCL is held low after the ACK clock of each received byte until `rx_take`. On reads, SCL is held low after each ACK until `tx_load` supplies the next byte. With `cfg_stretch`=0, `scl_oe` is never asserted.
- R8: With `cfg_filter`=1, a line changes level only after the new level has been present for 3 consecutive synchronised samples. An SDA pulse of 2 clocks while SCL is high produces no start or stop, and one of 3 clocks does.
- R9: With `cfg_wake`=1, a matching address is answered with NAK and `wake_irq` pulses exactly once. A non-matching address gives no pulse, and `rx_ready` never rises.
- R10: With `cfg_wake`=1, the filter is bypassed even when `cfg_filter`=1, so a 2-clock SDA pulse while SCL is high is seen as a start and a stop.
- R11: After `cfg_wake` returns to 0, the next matching address is ACKed and a write transfer completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stretch | input | 1 | Enable holding SCL low between bytes |
| cfg_filter | input | 1 | Enable the input glitch filter |
| cfg_wake | input | 1 | Low-speed address wake-up mode |
| cfg_comm | input | 1 | Enable answering the own address |
| own_addr | input | 7 | Own 7-bit address |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Captures `tx_data` as the next byte to send |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Received byte not yet taken |
| rx_take | input | 1 | Marks the received byte as taken |
| wake_irq | output | 1 | One-cycle pulse on an address match in wake-up mode |
| stop_seen | output | 1 | One-cycle pulse on a stop condition |

## Verification
The assertions assume that the four control bits change only while the bus is idle. They also assume that every SCL half period lasts longer than the synchroniser plus filter latency, so the slave's drive on SDA and SCL settles before the master's next edge. The bench changes configuration only between a stop and the next start. Its master model keeps each SCL quarter period at 10 clocks and waits for SCL to read high before timing a high phase, so a held clock is honoured. Glitch pulses are injected only while the bus is idle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int FILT_LEN = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_RX_HOLD,
        ST_TX_HOLD,
        ST_TX,
        ST_TX_ACK
    } i2cs_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [ADDR_W:0] frame,
                                      input logic [ADDR_W-1:0] own);
        return frame[ADDR_W:1] == own;
    endfunction

endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic filt_en,
    input  logic bypass,
    output logic line_o
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [RUN_W-1:0]       run_q;
    logic                   filt_q;
    logic                   samp;

    assign samp = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // A new level is adopted after FILT_LEN consecutive differing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            filt_q <= 1'b1;
        end else if (samp == filt_q) begin
            run_q <= '0;
        end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
            filt_q <= samp;
            run_q  <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign line_o = (filt_en && !bypass) ? filt_q : samp;

    assert_filter_settled_R8: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |-> ($past(samp) == filt_q && $past(samp, 2) == filt_q));

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start    = scl_q & scl & sda_q & ~sda;
        ev.stop     = scl_q & scl & ~sda_q & sda;
        ev.scl_rise = scl & ~scl_q;
        ev.scl_fall = ~scl & scl_q;
        ev.sda      = sda;
    end

endmodule

// File: rtl/i2c_wake_slave.sv
module i2c_wake_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FLT_LEN     = FILT_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_stretch,
    input  logic              cfg_filter,
    input  logic              cfg_wake,
    input  logic              cfg_comm,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              rx_take,
    output logic              wake_irq,
    output logic              stop_seen
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, cond_lines;
    bus_ev_t          ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        i2cs_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FLT_LEN)) u_cond (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_lines[g]),
            .filt_en(cfg_filter),
            .bypass (cfg_wake),
            .line_o (cond_lines[g])
        );
    end

    i2cs_bus_events u_ev (
        .clk(clk),
        .rst(rst),
        .scl(cond_lines[0]),
        .sda(cond_lines[1]),
        .ev (ev)
    );

    i2cs_state_e       state_q;
    logic [DATA_W-1:0] sh_q, rx_q, tx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sda_low_q, scl_low_q, rw_q, nack_q;
    logic              rx_rdy_q, tx_full_q, wake_q, stop_q;
    logic              tx_go;

    assign tx_go = tx_full_q || !cfg_stretch;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            sh_q      <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            cnt_q     <= '0;
            sda_low_q <= 1'b0;
            scl_low_q <= 1'b0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            rx_rdy_q  <= 1'b0;
            tx_full_q <= 1'b0;
            wake_q    <= 1'b0;
            stop_q    <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            stop_q <= 1'b0;
            if (tx_load) begin
                tx_q      <= tx_data;
                tx_full_q <= 1'b1;
            end
            if (rx_take) rx_rdy_q <= 1'b0;

            if (ev.stop) begin
                state_q   <= ST_IDLE;
                sda_low_q <= 1'b0;
                scl_low_q <= 1'b0;
                stop_q    <= 1'b1;
            end else if (ev.start) begin
                state_q   <= ST_ADDR;
                cnt_q     <= '0;
                sda_low_q <= 1'b0;
                scl_low_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_ADDR, ST_RX: begin
                        if (ev.scl_rise && cnt_q != CNT_W'(DATA_W)) begin
                            sh_q  <= {sh_q[DATA_W-2:0], ev.sda};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (ev.scl_fall && cnt_q == CNT_W'(DATA_W)) begin
                            if (state_q == ST_RX) begin
                                rx_q      <= sh_q;
                                rx_rdy_q  <= 1'b1;
                                sda_low_q <= 1'b1;
                                state_q   <= ST_RX_ACK;
                            end else begin
                                rw_q <= sh_q[0];
                                if (addr_hit(sh_q, own_addr) && cfg_wake) begin
                                    wake_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end else if (addr_hit(sh_q, own_addr) && cfg_comm) begin
                                    sda_low_q <= 1'b1;
                                    state_q   <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_TX_ACK: begin
                        if (ev.scl_rise) nack_q <= ev.sda;
                        if (ev.scl_fall) begin
                            sda_low_q <= 1'b0;
                            if (state_q == ST_ADDR_ACK && !rw_q) begin
                                state_q <= ST_RX;
                                cnt_q   <= '0;
                            end else if (state_q == ST_TX_ACK && nack_q) begin
                                state_q <= ST_IDLE;
                            end else if (tx_go) begin
                                sh_q      <= tx_q;
                                sda_low_q <= ~tx_q[DATA_W-1];
                                tx_full_q <= 1'b0;
                                cnt_q     <= '0;
                                state_q   <= ST_TX;
                            end else begin
                                scl_low_q <= 1'b1;
                                state_q   <= ST_TX_HOLD;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_low_q <= 1'b0;
                            cnt_q     <= '0;
                            if (cfg_stretch && rx_rdy_q && !rx_take) begin
                                scl_low_q <= 1'b1;
                                state_q   <= ST_RX_HOLD;
                            end else begin
                                state_q <= ST_RX;
                            end
                        end
                    end
                    ST_RX_HOLD: begin
                        if (!rx_rdy_q) begin
                            scl_low_q <= 1'b0;
                            state_q   <= ST_RX;
                        end
                    end
                    ST_TX_HOLD: begin
                        if (tx_full_q) begin
                            sh_q      <= tx_q;
                            sda_low_q <= ~tx_q[DATA_W-1];
                            tx_full_q <= 1'b0;
                            cnt_q     <= '0;
                            scl_low_q <= 1'b0;
                            state_q   <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt_q == CNT_W'(DATA_W)) begin
                                sda_low_q <= 1'b0;
                                state_q   <= ST_TX_ACK;
                            end else begin
                                sh_q      <= sh_q << 1;
                                sda_low_q <= ~sh_q[DATA_W-2];
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign scl_oe    = scl_low_q;
    assign sda_oe    = sda_low_q;
    assign rx_data   = rx_q;
    assign rx_ready  = rx_rdy_q;
    assign wake_irq  = wake_q;
    assign stop_seen = stop_q;

    assert_scl_hold_needs_cfg_R7: assert property (@(posedge clk) disable iff (rst)
        scl_low_q |-> cfg_stretch);

    assert_wake_nak_R9: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> (!sda_low_q && state_q == ST_IDLE));

    assert_comm_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR_ACK) |-> (cfg_comm && !cfg_wake));

    assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_low_q && !scl_low_q && stop_q));

    assert_no_data_in_wake_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wake && $past(cfg_wake)) |-> !$rose(rx_rdy_q));

endmodule

// File: tb/tb_i2c_wake_slave.sv
module tb_i2c_wake_slave;
    localparam int Q   = 10;
    localparam logic [6:0] OWN = 7'h2D;
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic cfg_stretch = 0, cfg_filter = 0, cfg_wake = 0, cfg_comm = 0;
    logic m_scl_low = 0, m_sda_low = 0;
    logic scl_oe, sda_oe, rx_ready, wake_irq, stop_seen;
    logic [7:0] tx_data = '0, rx_data;
    logic tx_load = 0, rx_take = 0;
    wire scl_bus = !(m_scl_low | scl_oe);
    wire sda_bus = !(m_sda_low | sda_oe);

    i2c_wake_slave dut (
        .clk(clk), .rst(rst),
        .cfg_stretch(cfg_stretch), .cfg_filter(cfg_filter),
        .cfg_wake(cfg_wake), .cfg_comm(cfg_comm), .own_addr(OWN),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .tx_data(tx_data), .tx_load(tx_load), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_take(rx_take),
        .wake_irq(wake_irq), .stop_seen(stop_seen)
    );

    int vectors = 0, fails = 0, cycles = 0;
    int stop_cnt = 0, irq_cnt = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (stop_seen) stop_cnt <= stop_cnt + 1;
        if (wake_irq)  irq_cnt  <= irq_cnt + 1;
        if (cycles > WD_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic mw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl_low = 0;
        do @(negedge clk); while (!scl_bus);
    endtask

    task automatic i2c_start();
        m_sda_low = 0; scl_up(); mw(Q);
        m_sda_low = 1; mw(Q);
        m_scl_low = 1; mw(Q);
    endtask

    task automatic i2c_stop();
        m_sda_low = 1; mw(Q);
        scl_up(); mw(Q);
        m_sda_low = 0; mw(Q);
    endtask

    task automatic bit_w(input logic b);
        m_sda_low = !b; mw(Q);
        scl_up(); mw(2 * Q);
        m_scl_low = 1; mw(Q);
    endtask

    task automatic bit_r(output logic b);
        m_sda_low = 0; mw(Q);
        scl_up(); mw(Q);
        b = sda_bus; mw(Q);
        m_scl_low = 1; mw(Q);
    endtask

    task automatic byte_w(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(a);
        acked = !a;
    endtask

    task automatic byte_r(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) bit_r(v[i]);
        bit_w(!ack);
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_data = v; tx_load = 1; @(negedge clk); tx_load = 0;
    endtask

    task automatic take_rx();
        rx_take = 1; @(negedge clk); rx_take = 0;
    endtask

    task automatic sda_glitch(input int len);
        m_sda_low = 1; mw(len); m_sda_low = 0; mw(12);
    endtask

    function automatic logic [7:0] wpat(input int i);
        return 8'((i * 29 + 7) & 255);
    endfunction
    function automatic logic [7:0] rpat(input int i);
        return 8'((i * 53 + 200) & 255);
    endfunction

    initial begin
        logic ack;
        logic [7:0] v;
        int s0;
        mw(4);
        rst = 0;
        mw(2);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 wake_irq", wake_irq, 0);
        chk("R1 stop_seen", stop_seen, 0);

        // R3 full address sweep, R2 stop pulse per transfer
        cfg_comm = 1;
        for (int a = 0; a < 128; a++) begin
            s0 = stop_cnt;
            i2c_start();
            byte_w({7'(a), 1'b0}, ack);
            chk("R3 address ack", ack, (a == OWN) ? 1 : 0);
            i2c_stop();
            mw(2);
            chk("R2 stop pulse", stop_cnt - s0, 1);
            chk("R2 lines released", {scl_oe, sda_oe}, 0);
        end

        // R4 communication disabled
        cfg_comm = 0;
        i2c_start(); byte_w({OWN, 1'b0}, ack); i2c_stop();
        chk("R4 own address nak", ack, 0);
        i2c_start(); byte_w({OWN, 1'b1}, ack); i2c_stop();
        chk("R4 own address nak read", ack, 0);
        cfg_comm = 1;

        // R5 write burst, filter on, no stretch
        cfg_filter = 1;
        i2c_start(); byte_w({OWN, 1'b0}, ack);
        chk("R5 addr ack", ack, 1);
        for (int i = 0; i < 12; i++) begin
            byte_w(wpat(i), ack);
            chk("R5 data ack", ack, 1);
            chk("R5 rx_ready", rx_ready, 1);
            chk("R5 rx_data", rx_data, wpat(i));
            chk("R7 no hold when off", scl_oe, 0);
            take_rx();
            chk("R5 rx_ready cleared", rx_ready, 0);
        end
        i2c_stop();

        // R6 read burst without stretch, master NAK ends it
        load_tx(rpat(0));
        i2c_start(); byte_w({OWN, 1'b1}, ack);
        chk("R6 read addr ack", ack, 1);
        for (int k = 0; k < 6; k++) begin
            if (k < 5) load_tx(rpat(k + 1));
            byte_r(v, k < 5);
            chk("R6 read data", v, rpat(k));
        end
        chk("R6 sda released after nak", sda_oe, 0);
        chk("R7 no hold when off", scl_oe, 0);
        i2c_stop();
        cfg_filter = 0;

        // R7 stretch on writes
        cfg_stretch = 1;
        i2c_start(); byte_w({OWN, 1'b0}, ack);
        chk("R7 addr ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            byte_w(wpat(i + 40), ack);
            mw(20);
            chk("R7 rx hold", scl_oe, 1);
            chk("R7 rx data", rx_data, wpat(i + 40));
            take_rx(); mw(4);
            chk("R7 rx release", scl_oe, 0);
        end
        i2c_stop();

        // R7 stretch on reads
        i2c_start(); byte_w({OWN, 1'b1}, ack);
        chk("R7 read addr ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            mw(20);
            chk("R7 tx hold", scl_oe, 1);
            load_tx(rpat(k + 9)); mw(4);
            chk("R7 tx release", scl_oe, 0);
            byte_r(v, k < 3);
            chk("R7 read data", v, rpat(k + 9));
        end
        chk("R6 sda released after nak", sda_oe, 0);
        i2c_stop();
        cfg_stretch = 0;

        // R8 / R10 glitch filter behaviour at idle
        mw(10);
        cfg_filter = 1; s0 = stop_cnt; sda_glitch(2);
        chk("R8 2-cycle glitch filtered", stop_cnt - s0, 0);
        s0 = stop_cnt; sda_glitch(3);
        chk("R8 3-cycle pulse passes", stop_cnt - s0, 1);
        cfg_filter = 0; s0 = stop_cnt; sda_glitch(2);
        chk("R8 unfiltered glitch seen", stop_cnt - s0, 1);
        cfg_filter = 1; cfg_wake = 1; mw(4); s0 = stop_cnt; sda_glitch(2);
        chk("R10 filter bypassed in wake mode", stop_cnt - s0, 1);

        // R9 wake-up detection sweep
        for (int d = -6; d <= 6; d++) begin
            logic [6:0] a;
            a = 7'(int'(OWN) + d);
            s0 = irq_cnt;
            i2c_start(); byte_w({a, d[0]}, ack); i2c_stop(); mw(2);
            chk("R9 always nak", ack, 0);
            chk("R9 irq count", irq_cnt - s0, (a == OWN) ? 1 : 0);
            chk("R9 no data", rx_ready, 0);
        end

        // R11 retry after clearing wake mode
        cfg_wake = 0; mw(4);
        s0 = irq_cnt;
        i2c_start(); byte_w({OWN, 1'b0}, ack);
        chk("R11 retry acked", ack, 1);
        byte_w(8'hC3, ack);
        chk("R11 data ack", ack, 1);
        chk("R11 rx data", rx_data, 8'hC3);
        i2c_stop();
        chk("R11 no irq", irq_cnt - s0, 0);
        take_rx();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule